// File: doc/BRIEF.md
# Character Display Command Executor

This block is the microprocessor-facing core of a character display controller. It receives accesses from a host through a register select, a read/write select, a one-cycle enable strobe and an 8-bit data bus. Register-select low addresses the command path; register-select high addresses the display data store or the glyph pattern store. The block decodes display commands, keeps the control state and holds a 32-byte display data RAM and a 16-byte character pattern RAM. Both RAMs share one address counter.

Every accepted access except a status read starts a busy period. The block rejects any access other than a status read while busy is high, and it flags each rejected access with a one-cycle pulse. The clear command fills the display RAM with blanks. Its busy period is counted in ticks of a slow oscillator, which reaches the block as a one-cycle `osc_tick` enable. All other busy periods are counted in clock cycles. The block drives no panel waveforms. In 4-bit mode it only stores the width bit and does not split transfers into nibbles.

Top module: `lcdc_exec`

## Requirements
- R1: After reset the block is in this state. Busy is low. `rd_data` is 0x00. The display, cursor and blink enables are off and `bus8` is 1. The shift offset is 0. The address counter is 0 and targets the display RAM. The entry direction is increment with no shift. Every display RAM byte holds 0x20.
- R2: When `rs`=0 and `rw`=0, the highest set bit of `din` selects the command. Bit 7 selects display address set, bit 6 glyph address set, bit 5 width set, bit 4 move, bit 3 enable control, bit 2 entry mode, bit 1 home and bit 0 clear. The value 0x00 changes no state.
- R3: The clear command (0x01) writes 0x20 into all 32 display RAM bytes. It sets the address counter to 0 targeting the display RAM and sets the shift offset to 0. It then holds busy for CLR_TICKS (34) `osc_tick` pulses.
- R4: The home command (0x02 or 0x03) sets the address counter to 0 targeting the display RAM and sets the shift offset to 0. Display RAM contents do not change.
- R5: The enable control command latches `din[2]` to `disp_on`, `din[1]` to `cursor_on` and `din[0]` to `blink_on`.
- R6: The entry mode command latches the direction from `din[1]` (1 means increment) and the shift-on-write flag from `din[0]`.
- R7: The move command uses `din[3]` to choose the target and `din[2]` to choose the direction. With `din[3]`=0, the cursor moves: the address counter goes up by 1 when `din[2]`=1 and down by 1 when `din[2]`=0. With `din[3]`=1, the display moves: the offset goes down by 1 when `din[2]`=1 and up by 1 when `din[2]`=0, modulo 32. RAM contents are untouched.
- R8: The width set command latches `din[4]` to `bus8`.
- R9: Address loading depends on the command. A command with bit 7 set loads `din[4:0]` and targets the display RAM. A command whose highest set bit is bit 6 loads `din[3:0]` and targets the glyph RAM. Counter steps wrap within 32 entries for the display RAM and within 16 for the glyph RAM.
- R10: A status read (`rs`=0, `rw`=1) is accepted even while busy and changes no state. From the next cycle `rd_data` shows {busy, 0, 0, address[4:0]}, where busy is the value in the cycle of the read.
- R11: A data write (`rs`=1, `rw`=0) stores `din` at the counter address in the targeted RAM. A data read (`rs`=1, `rw`=1) puts that byte on `rd_data` from the next cycle. After either access the counter steps one entry in the entry direction. A write with shift-on-write set also moves the offset, up by 1 when incrementing and down by 1 when decrementing.
- R12: Every accepted access other than a status read raises busy from the next cycle. For every command except clear, busy lasts CMD_CYCLES (2) clock cycles.
- R13: While busy is high, any access other than a status read is dropped. A dropped access changes no state, and `ignored` pulses high for one cycle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse per slow oscillator period |
| en | input | 1 | Access strobe, one cycle per access |
| rs | input | 1 | 0 selects command or status, 1 selects RAM data |
| rw | input | 1 | 1 selects read, 0 selects write |
| din | input | 8 | Write data or command byte |
| rd_data | output | 8 | Result of the latest accepted read |
| busy | output | 1 | Command in progress |
| ignored | output | 1 | Pulses one cycle after a dropped access |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Cursor blink enable |
| bus8 | output | 1 | Interface width bit, 1 means 8 bits |
| shift_ofs | output | 5 | Display shift offset |

## Verification
The overlap of interest is a busy period, above all the long clear, with a new host access in the same cycle. A dropped write and an accepted status read must then resolve in opposite ways. The bench provokes this in two ways. It issues accesses on back-to-back cycles after short commands, and it writes data and polls status while a clear counts oscillator ticks. A behavioural model compares the dropped-access pulse, busy, the status byte and every control output with the design on each clock. After the clear ends, reads of the display RAM show whether the dropped write left any trace.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_CLEAR,
        OP_HOME,
        OP_ENTRY,
        OP_ENABLES,
        OP_MOVE,
        OP_WIDTH,
        OP_GLYPH_ADDR,
        OP_DISP_ADDR
    } op_e;

    typedef enum logic [1:0] {
        ACC_CMD  = 2'b00,
        ACC_STAT = 2'b01,
        ACC_WR   = 2'b10,
        ACC_RD   = 2'b11
    } acc_e;

endpackage

// File: rtl/lcdc_decode.sv
module lcdc_decode
    import lcdc_pkg::*;
(
    input  logic [7:0] cmd,
    output op_e        op
);
    // highest set bit wins
    always_comb begin
        casez (cmd)
            8'b1???_????: op = OP_DISP_ADDR;
            8'b01??_????: op = OP_GLYPH_ADDR;
            8'b001?_????: op = OP_WIDTH;
            8'b0001_????: op = OP_MOVE;
            8'b0000_1???: op = OP_ENABLES;
            8'b0000_01??: op = OP_ENTRY;
            8'b0000_001?: op = OP_HOME;
            8'b0000_0001: op = OP_CLEAR;
            default:      op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/lcdc_addr_step.sv
module lcdc_addr_step #(
    parameter int DD_AW = 5,
    parameter int CG_AW = 4
) (
    input  logic [DD_AW-1:0] addr,
    input  logic             glyph,
    input  logic             up,
    output logic [DD_AW-1:0] next_addr
);
    localparam logic [DD_AW-1:0] DD_ONE = DD_AW'(1);
    localparam logic [CG_AW-1:0] CG_ONE = CG_AW'(1);

    logic [CG_AW-1:0] cg_next;
    logic [DD_AW-1:0] dd_next;

    always_comb begin
        cg_next = up ? (addr[CG_AW-1:0] + CG_ONE) : (addr[CG_AW-1:0] - CG_ONE);
        dd_next = up ? (addr + DD_ONE) : (addr - DD_ONE);
        next_addr = glyph ? DD_AW'(cg_next) : dd_next;
    end
endmodule

// File: rtl/lcdc_busy_timer.sv
module lcdc_busy_timer #(
    parameter int CLR_TICKS  = 34,
    parameter int CMD_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic long_op,
    input  logic osc_tick,
    output logic busy
);
    localparam int MAXV = (CLR_TICKS > CMD_CYCLES) ? CLR_TICKS : CMD_CYCLES;
    localparam int CW   = $clog2(MAXV + 1);
    localparam logic [CW-1:0] LONG_LD  = CW'(CLR_TICKS);
    localparam logic [CW-1:0] SHORT_LD = CW'(CMD_CYCLES);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          slow;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.cnt  = long_op ? LONG_LD : SHORT_LD;
            tmr_d.slow = long_op;
        end else if (tmr_q.cnt != '0 && (!tmr_q.slow || osc_tick)) begin
            tmr_d.cnt = tmr_q.cnt - CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy = (tmr_q.cnt != '0);
endmodule

// File: rtl/lcdc_char_ram.sv
module lcdc_char_ram #(
    parameter int         DD_AW = 5,
    parameter int         CG_AW = 4,
    parameter logic [7:0] BLANK = 8'h20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_en,
    input  logic             sel_glyph,
    input  logic [DD_AW-1:0] addr,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data
);
    localparam int DD_N = 1 << DD_AW;
    localparam int CG_N = 1 << CG_AW;

    logic [7:0] dd_cells [DD_N];
    logic [7:0] cg_cells [CG_N];

    for (genvar i = 0; i < DD_N; i++) begin : g_dd
        logic [7:0] cell_d, cell_q;
        always_comb begin
            cell_d = cell_q;
            if (clear)
                cell_d = BLANK;
            else if (wr_en && !sel_glyph && addr == DD_AW'(i))
                cell_d = wr_data;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cell_q <= BLANK;
            else        cell_q <= cell_d;
        end
        assign dd_cells[i] = cell_q;
    end

    for (genvar j = 0; j < CG_N; j++) begin : g_cg
        logic [7:0] cell_d, cell_q;
        always_comb begin
            cell_d = cell_q;
            if (wr_en && sel_glyph && addr[CG_AW-1:0] == CG_AW'(j))
                cell_d = wr_data;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cell_q <= '0;
            else        cell_q <= cell_d;
        end
        assign cg_cells[j] = cell_q;
    end

    assign rd_data = sel_glyph ? cg_cells[addr[CG_AW-1:0]] : dd_cells[addr];
endmodule

// File: rtl/lcdc_exec.sv
module lcdc_exec
    import lcdc_pkg::*;
#(
    parameter int DD_AW      = 5,
    parameter int CG_AW      = 4,
    parameter int CLR_TICKS  = 34,
    parameter int CMD_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic             en,
    input  logic             rs,
    input  logic             rw,
    input  logic [7:0]       din,
    output logic [7:0]       rd_data,
    output logic             busy,
    output logic             ignored,
    output logic             disp_on,
    output logic             cursor_on,
    output logic             blink_on,
    output logic             bus8,
    output logic [DD_AW-1:0] shift_ofs
);
    localparam logic [DD_AW-1:0] OFS_ONE = DD_AW'(1);
    localparam int               PAD     = 7 - DD_AW;

    typedef struct packed {
        logic [DD_AW-1:0] ac;
        logic             glyph;
        logic             inc;
        logic             shw;
        logic             dsp;
        logic             cur;
        logic             blk;
        logic             wide;
        logic [DD_AW-1:0] ofs;
        logic [7:0]       dout;
        logic             ign;
    } st_t;

    st_t st_d, st_q;

    op_e              op;
    acc_e             kind;
    logic             is_stat, accept;
    logic             tmr_start, tmr_long;
    logic             ram_clear, ram_wr;
    logic [7:0]       ram_rd;
    logic             step_up;
    logic [DD_AW-1:0] ac_stepped;

    lcdc_decode u_dec (
        .cmd (din),
        .op  (op)
    );

    assign kind    = acc_e'({rs, rw});
    assign is_stat = (kind == ACC_STAT);
    assign accept  = en && (is_stat || !busy);
    assign step_up = rs ? st_q.inc : din[2];

    lcdc_addr_step #(.DD_AW(DD_AW), .CG_AW(CG_AW)) u_step (
        .addr      (st_q.ac),
        .glyph     (st_q.glyph),
        .up        (step_up),
        .next_addr (ac_stepped)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ign  = en && busy && !is_stat;
        ram_clear = 1'b0;
        ram_wr    = 1'b0;
        tmr_start = accept && !is_stat;
        tmr_long  = 1'b0;
        if (accept) begin
            unique case (kind)
                ACC_STAT: st_d.dout = {busy, {PAD{1'b0}}, st_q.ac};
                ACC_WR: begin
                    ram_wr  = 1'b1;
                    st_d.ac = ac_stepped;
                    if (st_q.shw)
                        st_d.ofs = st_q.inc ? (st_q.ofs + OFS_ONE) : (st_q.ofs - OFS_ONE);
                end
                ACC_RD: begin
                    st_d.dout = ram_rd;
                    st_d.ac   = ac_stepped;
                end
                ACC_CMD: begin
                    unique case (op)
                        OP_CLEAR: begin
                            ram_clear  = 1'b1;
                            tmr_long   = 1'b1;
                            st_d.ac    = '0;
                            st_d.glyph = 1'b0;
                            st_d.ofs   = '0;
                        end
                        OP_HOME: begin
                            st_d.ac    = '0;
                            st_d.glyph = 1'b0;
                            st_d.ofs   = '0;
                        end
                        OP_ENTRY: begin
                            st_d.inc = din[1];
                            st_d.shw = din[0];
                        end
                        OP_ENABLES: begin
                            st_d.dsp = din[2];
                            st_d.cur = din[1];
                            st_d.blk = din[0];
                        end
                        OP_MOVE: begin
                            if (din[3])
                                st_d.ofs = din[2] ? (st_q.ofs - OFS_ONE) : (st_q.ofs + OFS_ONE);
                            else
                                st_d.ac = ac_stepped;
                        end
                        OP_WIDTH: st_d.wide = din[4];
                        OP_GLYPH_ADDR: begin
                            st_d.ac    = DD_AW'(din[CG_AW-1:0]);
                            st_d.glyph = 1'b1;
                        end
                        OP_DISP_ADDR: begin
                            st_d.ac    = din[DD_AW-1:0];
                            st_d.glyph = 1'b0;
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.inc  <= 1'b1;
            st_q.wide <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    lcdc_busy_timer #(.CLR_TICKS(CLR_TICKS), .CMD_CYCLES(CMD_CYCLES)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (tmr_start),
        .long_op  (tmr_long),
        .osc_tick (osc_tick),
        .busy     (busy)
    );

    lcdc_char_ram #(.DD_AW(DD_AW), .CG_AW(CG_AW)) u_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (ram_clear),
        .wr_en     (ram_wr),
        .sel_glyph (st_q.glyph),
        .addr      (st_q.ac),
        .wr_data   (din),
        .rd_data   (ram_rd)
    );

    assign rd_data   = st_q.dout;
    assign ignored   = st_q.ign;
    assign disp_on   = st_q.dsp;
    assign cursor_on = st_q.cur;
    assign blink_on  = st_q.blk;
    assign bus8      = st_q.wide;
    assign shift_ofs = st_q.ofs;
endmodule

module lcdc_exec_chk #(
    parameter int DD_AW = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             rs,
    input logic             rw,
    input logic [7:0]       din,
    input logic [7:0]       rd_data,
    input logic             busy,
    input logic             ignored,
    input logic             disp_on,
    input logic             cursor_on,
    input logic             blink_on,
    input logic             bus8,
    input logic [DD_AW-1:0] shift_ofs
);
    logic stat_acc, plain_acc;
    assign stat_acc  = en && !rs && rw;
    assign plain_acc = en && !stat_acc;

    // R12
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_acc && !busy) |=> busy);

    // R13
    drop_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_acc && busy) |=> ignored);

    // R13
    no_false_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(plain_acc && busy) |=> !ignored);

    // R13
    drop_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_acc && busy) |=> ($stable(disp_on) && $stable(cursor_on) && $stable(blink_on)
                                 && $stable(bus8) && $stable(shift_ofs)));

    // R10
    status_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_acc |=> (rd_data[7] == $past(busy) && rd_data[6:5] == 2'b00));

    // R5
    enables_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_acc && !busy && !rs && din[7:3] == 5'b00001)
            |=> (disp_on == $past(din[2]) && cursor_on == $past(din[1]) && blink_on == $past(din[0])));

    // R8
    width_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_acc && !busy && !rs && din[7:5] == 3'b001) |=> (bus8 == $past(din[4])));
endmodule

bind lcdc_exec lcdc_exec_chk #(.DD_AW(DD_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .rs        (rs),
    .rw        (rw),
    .din       (din),
    .rd_data   (rd_data),
    .busy      (busy),
    .ignored   (ignored),
    .disp_on   (disp_on),
    .cursor_on (cursor_on),
    .blink_on  (blink_on),
    .bus8      (bus8),
    .shift_ofs (shift_ofs)
);

// File: tb/tb_lcdc_exec.sv
module tb_lcdc_exec;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic       en = 1'b0, rs = 1'b0, rw = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] rd_data;
    logic       busy, ignored, disp_on, cursor_on, blink_on, bus8;
    logic [4:0] shift_ofs;

    always #5 clk = ~clk;

    lcdc_exec dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .en(en), .rs(rs), .rw(rw),
        .din(din), .rd_data(rd_data), .busy(busy), .ignored(ignored),
        .disp_on(disp_on), .cursor_on(cursor_on), .blink_on(blink_on),
        .bus8(bus8), .shift_ofs(shift_ofs)
    );

    int checks = 0, errors = 0, cyc = 0, tcnt = 0;
    bit live = 0, done = 0;

    // behavioural reference
    int  m_ac, m_ofs, m_dout, bcnt;
    bit  m_cg, m_id, m_sh, m_d, m_c, m_b, m_dl, m_ign, bslow;
    int  ddm [32];
    int  cgm [16];

    function automatic int mstep(int a, bit up, bit g);
        int m = g ? 16 : 32;
        return (a + (up ? 1 : m - 1)) % m;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ac = 0; m_ofs = 0; m_dout = 0; bcnt = 0; bslow = 0;
            m_cg = 0; m_id = 1; m_sh = 0; m_d = 0; m_c = 0; m_b = 0; m_dl = 1; m_ign = 0;
            foreach (ddm[i]) ddm[i] = 8'h20;
            foreach (cgm[i]) cgm[i] = 0;
        end else begin
            bit mb, st, started, lng;
            mb = (bcnt > 0);
            st = en && !rs && rw;
            m_ign = en && mb && !st;
            started = 0; lng = 0;
            if (en && (st || !mb)) begin
                if (st) m_dout = (mb ? 128 : 0) + m_ac;
                else begin
                    started = 1;
                    if (rs && !rw) begin
                        if (m_cg) cgm[m_ac] = din; else ddm[m_ac] = din;
                        if (m_sh) m_ofs = (m_ofs + (m_id ? 1 : 31)) % 32;
                        m_ac = mstep(m_ac, m_id, m_cg);
                    end else if (rs && rw) begin
                        m_dout = m_cg ? cgm[m_ac] : ddm[m_ac];
                        m_ac = mstep(m_ac, m_id, m_cg);
                    end else if (din[7]) begin m_ac = din & 31; m_cg = 0; end
                    else if (din[6]) begin m_ac = din & 15; m_cg = 1; end
                    else if (din[5]) m_dl = din[4];
                    else if (din[4]) begin
                        if (din[3]) m_ofs = (m_ofs + (din[2] ? 31 : 1)) % 32;
                        else m_ac = mstep(m_ac, din[2], m_cg);
                    end
                    else if (din[3]) begin m_d = din[2]; m_c = din[1]; m_b = din[0]; end
                    else if (din[2]) begin m_id = din[1]; m_sh = din[0]; end
                    else if (din[1]) begin m_ac = 0; m_cg = 0; m_ofs = 0; end
                    else if (din[0]) begin
                        foreach (ddm[i]) ddm[i] = 8'h20;
                        m_ac = 0; m_cg = 0; m_ofs = 0; lng = 1;
                    end
                end
            end
            if (started) begin bcnt = lng ? 34 : 2; bslow = lng; end
            else if (bcnt > 0 && (!bslow || osc_tick)) bcnt--;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R3 R12", "busy", busy, bcnt > 0);
        chk("R13", "ignored", ignored, m_ign);
        chk("R10 R11", "rd_data", rd_data, m_dout);
        chk("R5", "disp_on", disp_on, m_d);
        chk("R5", "cursor_on", cursor_on, m_c);
        chk("R5", "blink_on", blink_on, m_b);
        chk("R8", "bus8", bus8, m_dl);
        chk("R7", "shift_ofs", shift_ofs, m_ofs);
    endtask

    task automatic step(input bit e, input bit r, input bit w, input logic [7:0] d);
        @(negedge clk);
        if (live) compare_all();
        en = e; rs = r; rw = w; din = d;
        tcnt++;
        osc_tick = (tcnt % 3 == 0);
    endtask

    task automatic settle();
        step(0, 0, 0, 8'h00);
        while (bcnt > 0) step(0, 0, 0, 8'h00);
        step(0, 0, 0, 8'h00);
    endtask

    task automatic cmd(input logic [7:0] c);
        step(1, 0, 0, c); settle();
    endtask
    task automatic wr(input logic [7:0] v);
        step(1, 1, 0, v); settle();
    endtask
    task automatic rd();
        step(1, 1, 1, 8'h00); settle();
    endtask
    task automatic stat();
        step(1, 0, 1, 8'h00); settle();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step(0, 0, 0, 8'h00);
        rst_n = 1'b1;
        step(0, 0, 0, 8'h00);
        live = 1;
        step(0, 0, 0, 8'h00);
        // R1 reset state
        chk("R1", "busy", busy, 0); chk("R1", "rd_data", rd_data, 0);
        chk("R1", "disp_on", disp_on, 0); chk("R1", "bus8", bus8, 1);
        chk("R1", "shift_ofs", shift_ofs, 0);
        stat(); chk("R1", "status", rd_data, 8'h00);
        rd();   chk("R1", "blank", rd_data, 8'h20);
        // R8 width
        cmd(8'h2F); chk("R8", "bus8 low", bus8, 0);
        cmd(8'h3F); chk("R8", "bus8 high", bus8, 1);
        // R5 enables
        cmd(8'h0D);
        chk("R5", "disp", disp_on, 1); chk("R5", "cur", cursor_on, 0); chk("R5", "blk", blink_on, 1);
        // R9 address loading
        cmd(8'h9E); stat(); chk("R9", "dd addr", rd_data, 8'h1E);
        cmd(8'h4F); stat(); chk("R9", "cg addr", rd_data, 8'h0F);
        // R6 R11 increment with wrap
        cmd(8'h06); cmd(8'h9E);
        wr(8'hAA); wr(8'hBB); wr(8'hCC);
        stat(); chk("R11", "ac after writes", rd_data, 8'h01);
        cmd(8'h9E); rd(); chk("R11", "read AA", rd_data, 8'hAA);
        rd(); chk("R11", "read BB", rd_data, 8'hBB);
        rd(); chk("R11", "read CC", rd_data, 8'hCC);
        // R6 decrement
        cmd(8'h04); cmd(8'h80); wr(8'h11);
        stat(); chk("R6", "dec wrap", rd_data, 8'h1F);
        // R9 glyph wrap and separation
        cmd(8'h06); cmd(8'h4F); wr(8'h5A);
        stat(); chk("R9", "cg wrap", rd_data, 8'h00);
        cmd(8'h4F); rd(); chk("R11", "cg read", rd_data, 8'h5A);
        cmd(8'h8F); rd(); chk("R11", "dd untouched", rd_data, 8'h20);
        // R7 moves
        cmd(8'h80); cmd(8'h14); stat(); chk("R7", "cursor right", rd_data, 8'h01);
        cmd(8'h10); cmd(8'h13); stat(); chk("R7", "cursor left wrap", rd_data, 8'h1F);
        cmd(8'h18); chk("R7", "disp left", shift_ofs, 1);
        cmd(8'h1C); cmd(8'h1F); chk("R7", "disp right wrap", shift_ofs, 31);
        stat(); chk("R7", "ac kept", rd_data, 8'h1F);
        // R11 shift on write
        cmd(8'h07); wr(8'h42); chk("R11", "shw inc", shift_ofs, 0);
        cmd(8'h05); wr(8'h43); chk("R11", "shw dec", shift_ofs, 31);
        // R4 home
        cmd(8'h03); chk("R4", "ofs", shift_ofs, 0);
        stat(); chk("R4", "ac", rd_data, 8'h00);
        cmd(8'h06); cmd(8'h9E); rd(); chk("R4", "ram kept", rd_data, 8'hAA);
        // R2 no-op
        cmd(8'h00); stat(); chk("R2", "nop ac", rd_data, 8'h1F);
        chk("R2", "nop disp", disp_on, 1);
        // R12 R13 back-to-back
        step(1, 0, 0, 8'h08); step(1, 0, 0, 8'h0F); settle();
        chk("R13", "dropped enables", disp_on, 0);
        step(1, 0, 0, 8'h02); step(1, 0, 1, 8'h00); settle();
        chk("R10", "status while busy", rd_data, 8'h80);
        // R3 clear with overlapping accesses
        cmd(8'h80); wr(8'h77); cmd(8'h18);
        step(1, 0, 0, 8'h01);
        step(0, 0, 0, 8'h00);
        step(1, 1, 0, 8'h99);
        repeat (10) step(0, 0, 0, 8'h00);
        step(1, 0, 1, 8'h00);
        step(0, 0, 0, 8'h00);
        step(0, 0, 0, 8'h00);
        chk("R3", "busy in clear", rd_data, 8'h80);
        chk("R3", "still busy", busy, 1);
        settle();
        chk("R3", "ofs", shift_ofs, 0);
        stat(); chk("R3", "ac", rd_data, 8'h00);
        rd(); chk("R3", "blanked", rd_data, 8'h20);
        rd(); chk("R13", "drop left no write", rd_data, 8'h20);
        step(0, 0, 0, 8'h00);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule